// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the hardwired sequencer for a processor datapath that carries each instruction through several clock cycles. Every cycle it drives the datapath's steering and enable lines: memory address source, memory read and write, instruction register load, ALU operand selects and operation class, program counter source and write enables, and register file destination and write-back source. It does this from a ten-state machine held in a four-bit register.

The control lines depend only on the current state. The opcode field of the instruction register is used in exactly two states, to choose the path: once when the instruction is decoded, and once more when a memory address has been computed. Each instruction class runs through its own sequence of states and then returns to the fetch state. The surrounding datapath owns all data values. The sequencer holds nothing but its state.

Top module: `mc_seq_ctrl`

## Requirements
- R1: A high `rst` at a rising clock edge puts the machine in the fetch state (state 0) at that edge, whatever state it was in.
- R2: Fetch (state 0) drives mem_rd=1, instr_ld=1, pc_wr=1, mem_addr_sel=0, alu_a_sel=0, alu_b_sel=01, alu_op=00 and pc_src=00, with every other output low. Its next state is always decode (state 1).
- R3: Decode (state 1) drives alu_a_sel=0, alu_b_sel=11 and alu_op=00, with every other output low. On the opcode it goes to state 2 for 100011 (load) or 101011 (store), to state 6 for 000000 (register op), to state 8 for 000100 (branch-if-equal) and to state 9 for 000010 (jump).
- R4: In decode, any opcode other than those five returns the machine to fetch.
- R5: Address state 2 drives alu_a_sel=1, alu_b_sel=10 and alu_op=00. It goes to state 3 for a load opcode, to state 5 for a store opcode and to fetch for any other opcode.
- R6: Load read state 3 drives mem_rd=1 and mem_addr_sel=1 and goes to state 4. Load write-back state 4 drives rf_wr=1, wb_from_mem=1 and rf_dst_sel=0 and goes to fetch.
- R7: Store state 5 drives mem_wr=1 and mem_addr_sel=1 and goes to fetch.
- R8: Register-op execute state 6 drives alu_a_sel=1, alu_b_sel=00 and alu_op=10 and goes to state 7. Completion state 7 drives rf_wr=1, rf_dst_sel=1 and wb_from_mem=0 and goes to fetch.
- R9: Branch state 8 drives alu_a_sel=1, alu_b_sel=00, alu_op=01, pc_wr_cond=1 and pc_src=01 and goes to fetch.
- R10: Jump state 9 drives pc_wr=1 and pc_src=10 and goes to fetch.
- R11: The opcode has no effect in any state other than 1 and 2. A load whose opcode changes during its read state still writes back and then fetches.
- R12: rf_wr is high only in states 4 and 7. mem_rd and mem_wr are never high together. Any output a state does not name is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset to fetch |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write when the ALU result is zero |
| mem_addr_sel | output | 1 | Memory address source: 0 program counter, 1 ALU result register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| instr_ld | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Register write data: 0 ALU result, 1 memory data register |
| pc_src | output | 2 | Program counter source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_op | output | 2 | ALU class: 00 add, 01 subtract, 10 function field |
| alu_a_sel | output | 1 | ALU first operand: 0 program counter, 1 register A |
| alu_b_sel | output | 2 | ALU second operand: 00 B, 01 constant 4, 10 extended immediate, 11 shifted immediate |
| rf_wr | output | 1 | Register file write enable |
| rf_dst_sel | output | 1 | Destination field: 0 rt, 1 rd |

## Verification
The outputs are decoded combinationally from the state register, so they reflect a state in the same cycle the machine enters it. The opcode takes effect one rising edge after it is presented in state 1 or 2, and reset takes effect at the first rising edge where it is high. The bench drives inputs and samples outputs only on falling edges. It compares each sample against the state that the requirements predict, counting one edge per state. Each vector's path therefore lines up exactly with the cycles it takes.

// File: rtl/mc_seq_ctrl_pkg.sv
package mc_seq_ctrl_pkg;

    localparam int OPC_W = 6;
    localparam int ST_W  = 4;

    localparam logic [OPC_W-1:0] OPC_REG  = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_JMP  = 6'b000010;
    localparam logic [OPC_W-1:0] OPC_BEQ  = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_LOAD = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STOR = 6'b101011;

    typedef enum logic [ST_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_LDRD   = 4'd3,
        ST_LDWB   = 4'd4,
        ST_STWR   = 4'd5,
        ST_REXE   = 4'd6,
        ST_RDONE  = 4'd7,
        ST_BRANCH = 4'd8,
        ST_JUMP   = 4'd9
    } state_e;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       mem_addr_sel;
        logic       mem_rd;
        logic       mem_wr;
        logic       instr_ld;
        logic       wb_from_mem;
        logic [1:0] pc_src;
        logic [1:0] alu_op;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic       rf_wr;
        logic       rf_dst_sel;
    } ctl_t;

    typedef struct packed {
        state_e state;
    } seq_regs_t;

endpackage

// File: rtl/mc_seq_next.sv
module mc_seq_next
    import mc_seq_ctrl_pkg::*;
(
    input  state_e           cur,
    input  logic [OPC_W-1:0] opcode,
    output state_e           nxt
);

    always_comb begin
        nxt = ST_FETCH;
        case (cur)
            ST_FETCH: nxt = ST_DECODE;
            ST_DECODE: begin
                case (opcode)
                    OPC_LOAD, OPC_STOR: nxt = ST_ADDR;
                    OPC_REG:            nxt = ST_REXE;
                    OPC_BEQ:            nxt = ST_BRANCH;
                    OPC_JMP:            nxt = ST_JUMP;
                    default:            nxt = ST_FETCH;
                endcase
            end
            ST_ADDR: begin
                if (opcode == OPC_LOAD)      nxt = ST_LDRD;
                else if (opcode == OPC_STOR) nxt = ST_STWR;
                else                         nxt = ST_FETCH;
            end
            ST_LDRD: nxt = ST_LDWB;
            ST_REXE: nxt = ST_RDONE;
            default: nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mc_seq_outdec.sv
module mc_seq_outdec
    import mc_seq_ctrl_pkg::*;
(
    input  state_e cur,
    output ctl_t   ctl
);

    always_comb begin
        ctl = '0;
        case (cur)
            ST_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.instr_ld  = 1'b1;
                ctl.pc_wr     = 1'b1;
                ctl.alu_b_sel = 2'b01;
            end
            ST_DECODE: ctl.alu_b_sel = 2'b11;
            ST_ADDR: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = 2'b10;
            end
            ST_LDRD: begin
                ctl.mem_rd       = 1'b1;
                ctl.mem_addr_sel = 1'b1;
            end
            ST_LDWB: begin
                ctl.rf_wr       = 1'b1;
                ctl.wb_from_mem = 1'b1;
            end
            ST_STWR: begin
                ctl.mem_wr       = 1'b1;
                ctl.mem_addr_sel = 1'b1;
            end
            ST_REXE: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_op    = 2'b10;
            end
            ST_RDONE: begin
                ctl.rf_wr      = 1'b1;
                ctl.rf_dst_sel = 1'b1;
            end
            ST_BRANCH: begin
                ctl.alu_a_sel  = 1'b1;
                ctl.alu_op     = 2'b01;
                ctl.pc_wr_cond = 1'b1;
                ctl.pc_src     = 2'b01;
            end
            ST_JUMP: begin
                ctl.pc_wr  = 1'b1;
                ctl.pc_src = 2'b10;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
    import mc_seq_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    output logic             pc_wr,
    output logic             pc_wr_cond,
    output logic             mem_addr_sel,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             instr_ld,
    output logic             wb_from_mem,
    output logic [1:0]       pc_src,
    output logic [1:0]       alu_op,
    output logic             alu_a_sel,
    output logic [1:0]       alu_b_sel,
    output logic             rf_wr,
    output logic             rf_dst_sel
);

    seq_regs_t regs_d, regs_q;
    state_e    nxt_state;
    ctl_t      ctl;

    mc_seq_next next_i (
        .cur    (regs_q.state),
        .opcode (opcode),
        .nxt    (nxt_state)
    );

    mc_seq_outdec dec_i (
        .cur (regs_q.state),
        .ctl (ctl)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.state = nxt_state;
        if (rst) regs_d.state = ST_FETCH;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign pc_wr        = ctl.pc_wr;
    assign pc_wr_cond   = ctl.pc_wr_cond;
    assign mem_addr_sel = ctl.mem_addr_sel;
    assign mem_rd       = ctl.mem_rd;
    assign mem_wr       = ctl.mem_wr;
    assign instr_ld     = ctl.instr_ld;
    assign wb_from_mem  = ctl.wb_from_mem;
    assign pc_src       = ctl.pc_src;
    assign alu_op       = ctl.alu_op;
    assign alu_a_sel    = ctl.alu_a_sel;
    assign alu_b_sel    = ctl.alu_b_sel;
    assign rf_wr        = ctl.rf_wr;
    assign rf_dst_sel   = ctl.rf_dst_sel;

endmodule

// File: rtl/mc_seq_ctrl_chk.sv
module mc_seq_ctrl_chk
    import mc_seq_ctrl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [OPC_W-1:0] opcode,
    input state_e           state_q,
    input logic             rf_wr,
    input logic             mem_rd,
    input logic             mem_wr
);

    p_reset_r1: assert property (@(posedge clk) rst |=> state_q == ST_FETCH);

    p_fetch_next_r2: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_FETCH |=> state_q == ST_DECODE);

    p_load_dispatch_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DECODE && opcode == OPC_LOAD) |=> state_q == ST_ADDR);

    p_jump_dispatch_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DECODE && opcode == OPC_JMP) |=> state_q == ST_JUMP);

    p_store_path_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ADDR && opcode == OPC_STOR) |=> state_q == ST_STWR);

    p_load_chain_r6: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_LDRD |=> state_q == ST_LDWB);

    p_reg_chain_r8: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_REXE |=> state_q == ST_RDONE);

    p_finish_return_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LDWB || state_q == ST_STWR || state_q == ST_RDONE ||
         state_q == ST_BRANCH || state_q == ST_JUMP) |=> state_q == ST_FETCH);

    p_rfwr_states_r12: assert property (@(posedge clk) disable iff (rst)
        rf_wr |-> (state_q == ST_LDWB || state_q == ST_RDONE));

    p_mem_excl_r12: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

endmodule

bind mc_seq_ctrl mc_seq_ctrl_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .opcode  (opcode),
    .state_q (regs_q.state),
    .rf_wr   (rf_wr),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr)
);

// File: tb/mc_seq_ctrl_tb_top.sv
module mc_seq_ctrl_tb_top;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'b000000;
    logic       pc_wr, pc_wr_cond, mem_addr_sel, mem_rd, mem_wr, instr_ld, wb_from_mem;
    logic [1:0] pc_src, alu_op, alu_b_sel;
    logic       alu_a_sel, rf_wr, rf_dst_sel;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_seq_ctrl dut_i (
        .clk(clk), .rst(rst), .opcode(opcode),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .mem_addr_sel(mem_addr_sel),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .instr_ld(instr_ld),
        .wb_from_mem(wb_from_mem), .pc_src(pc_src), .alu_op(alu_op),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .rf_wr(rf_wr),
        .rf_dst_sel(rf_dst_sel)
    );

    // {opcode[6], path length[3], third, fourth, fifth state[4 each]}
    localparam int NVEC = 8;
    localparam logic [20:0] VEC [NVEC] = '{
        {6'b100011, 3'd5, 4'd2, 4'd3, 4'd4},
        {6'b101011, 3'd4, 4'd2, 4'd5, 4'd0},
        {6'b000000, 3'd4, 4'd6, 4'd7, 4'd0},
        {6'b000100, 3'd3, 4'd8, 4'd0, 4'd0},
        {6'b000010, 3'd3, 4'd9, 4'd0, 4'd0},
        {6'b111111, 3'd2, 4'd0, 4'd0, 4'd0},
        {6'b000001, 3'd2, 4'd0, 4'd0, 4'd0},
        {6'b100011, 3'd5, 4'd2, 4'd3, 4'd4}
    };

    // Bus order: pc_wr pc_wr_cond mem_addr_sel mem_rd mem_wr instr_ld
    // wb_from_mem pc_src[2] alu_op[2] alu_a_sel alu_b_sel[2] rf_wr rf_dst_sel
    function automatic logic [15:0] exp_ctl(int s);
        logic pw = 0, pwc = 0, ads = 0, rd = 0, wr = 0, il = 0, wbm = 0;
        logic [1:0] ps = 0, ao = 0, bs = 0;
        logic as = 0, rw = 0, dst = 0;
        case (s)
            0: begin rd = 1; il = 1; pw = 1; bs = 2'b01; end
            1: bs = 2'b11;
            2: begin as = 1; bs = 2'b10; end
            3: begin rd = 1; ads = 1; end
            4: begin rw = 1; wbm = 1; end
            5: begin wr = 1; ads = 1; end
            6: begin as = 1; ao = 2'b10; end
            7: begin rw = 1; dst = 1; end
            8: begin as = 1; ao = 2'b01; pwc = 1; ps = 2'b01; end
            9: begin pw = 1; ps = 2'b10; end
            default: ;
        endcase
        return {pw, pwc, ads, rd, wr, il, wbm, ps, ao, as, bs, rw, dst};
    endfunction

    function automatic string req_of(int s);
        case (s)
            0: return "R2";
            1: return "R3";
            2: return "R5";
            3, 4: return "R6";
            5: return "R7";
            6, 7: return "R8";
            8: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string req, int s);
        logic [15:0] act;
        act = {pc_wr, pc_wr_cond, mem_addr_sel, mem_rd, mem_wr, instr_ld, wb_from_mem,
               pc_src, alu_op, alu_a_sel, alu_b_sel, rf_wr, rf_dst_sel};
        n_checks++;
        if (act !== exp_ctl(s)) begin
            n_errors++;
            $display("FAIL %s: outputs actual=%b expected=%b (state %0d)", req, act, exp_ctl(s), s);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", 0);
        rst = 1'b0;

        for (int v = 0; v < NVEC; v++) begin
            int path [5];
            int len;
            opcode = VEC[v][20:15];
            len = int'(VEC[v][14:12]);
            path[0] = 0; path[1] = 1;
            path[2] = int'(VEC[v][11:8]);
            path[3] = int'(VEC[v][7:4]);
            path[4] = int'(VEC[v][3:0]);
            for (int k = 0; k < len; k++) begin
                // illegal opcodes exercise R4: decode falls straight back to fetch
                check((len == 2 && k == 1) ? "R4" : req_of(path[k]), path[k]);
                step();
            end
            check(len == 2 ? "R4" : "R2", 0);
        end

        // R11: opcode altered during the load read state is ignored
        opcode = 6'b100011;
        step(); step();
        check("R5", 2);
        step();
        check("R6", 3);
        opcode = 6'b000100;
        step();
        check("R11", 4);
        step();
        check("R11", 0);

        // R5: address state with a non-memory opcode returns to fetch
        opcode = 6'b100011;
        step(); step();
        check("R5", 2);
        opcode = 6'b000000;
        step();
        check("R5", 0);

        // R11: opcode changed in the register-op execute state is ignored
        step(); step();
        check("R8", 6);
        opcode = 6'b000010;
        step();
        check("R11", 7);
        step();

        // R1: reset mid-instruction
        opcode = 6'b000000;
        step(); step();
        check("R8", 6);
        rst = 1'b1;
        step();
        check("R1", 0);
        step();
        check("R1", 0);
        rst = 1'b0;
        step();
        check("R2", 1);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule